// File: doc/BRIEF.md
# Parallel NFA Symbol Matcher

This block searches a byte stream for many patterns at the same time. It is built from an array of state elements. Each element owns a class table with one bit for each of the 256 byte values. Every cycle that carries a valid byte, that byte goes to all elements at once and serves as the read address into each table. The bit read out is the element's match result.

An element becomes active when it is enabled and its bit for the current byte is set. An element is enabled when it is marked as a start element, or when any element that was active after the previous byte links to it. One active element may enable any number of successors, so many partial matches advance side by side. A pattern of L bytes is therefore found after L bytes, whatever the number of patterns loaded.

Elements marked as reporting raise a report in the cycle after they become active. The report carries the set of reporting elements, the lowest index among them and the stream position of the byte that completed the match. Software loads the tables, links and flags through a single-bit write port while the stream is idle. A restart pulse drops all partial matches.

Top module: `nfa_matcher`

## Requirements
- R1: An enabled element becomes active on a valid byte `b` exactly when bit `b` of its class table is set. A table with several bits set accepts any of those bytes. Configuration kind 0 writes `cfg_data` into table bit `cfg_addr` of element `cfg_elem`.
- R2: An element whose start flag is set is enabled on every valid byte, so a match may begin at any stream position. Configuration kind 2 writes the start flag of element `cfg_elem`.
- R3: An element `i` that is active enables every element `j` with link (i, j) set for the next valid byte, and several successors may become active together. Configuration kind 1 writes link (`cfg_elem`, `cfg_addr[IDX_W-1:0]`).
- R4: An enabled element whose table bit for the byte is clear is inactive after that byte and enables no successors. An element that is not enabled never becomes active.
- R5: In the cycle after a valid byte, `rpt_vec` holds the elements that have their report flag set and became active on that byte. `rpt_valid` is high when that set is not empty, `rpt_idx` is the lowest index in it, and `rpt_offset` is the zero-based position of that byte counted since the last reset or restart. Configuration kind 3 writes the report flag of element `cfg_elem`.
- R6: A cycle with `sym_valid` low leaves the active set and the byte position unchanged, and `rpt_valid` is low in the following cycle.
- R7: A configuration write made in a cycle with `sym_valid` high is ignored.
- R8: A `restart` pulse clears the active set and the byte position. A byte presented in the same cycle is not consumed, and no report follows that cycle.
- R9: After reset all tables, links and flags are clear, the active set is empty, and all report outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 class bit, 1 link, 2 start flag, 3 report flag |
| cfg_elem | input | IDX_W | Element being configured (link source for kind 1) |
| cfg_addr | input | SYM_W | Table bit for kind 0, link destination for kind 1 |
| cfg_data | input | 1 | Value written |
| restart | input | 1 | Clear all partial matches and the byte position |
| sym_valid | input | 1 | Input byte qualifier |
| sym | input | SYM_W | Input byte |
| rpt_valid | output | 1 | At least one reporting element matched |
| rpt_vec | output | N_STE | Reporting elements that matched |
| rpt_idx | output | IDX_W | Lowest index in `rpt_vec` |
| rpt_offset | output | OFF_W | Stream position of the matching byte |

## Verification
The assertions check on every cycle the properties that hold at every step. The active set holds through idle cycles and is empty after a restart, and no element turns active without being enabled in the cycle before. No report follows a cycle without a consumed byte. The reported index names a set bit, and a table write lands at the addressed bit. Other behaviour depends on sequences and is shown only by the bench scenarios: whole patterns completing across links, byte classes, parallel branches, failure part way through, idle gaps inside a pattern, writes that are ignored and restarts between the bytes of a pattern. In each of these the outputs are compared against a behavioural model on every clock.

// File: rtl/nfa_pkg.sv
// Shared definitions of the NFA matcher: the configuration write kinds.
// Assumes: the kind codes are fixed by the software programming model.
package nfa_pkg;
    typedef enum logic [1:0] {
        CFG_CLASS  = 2'd0,
        CFG_LINK   = 2'd1,
        CFG_START  = 2'd2,
        CFG_REPORT = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/nfa_ste.sv
// One state element. It holds a class table with one bit per symbol value,
// a start flag and a report flag, and reads the table at the broadcast
// symbol. Assumes: the write strobes arrive already decoded and gated.
module nfa_ste #(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cls_we,
    input  logic             start_we,
    input  logic             rpt_we,
    input  logic [SYM_W-1:0] cfg_addr,
    input  logic             cfg_data,
    input  logic [SYM_W-1:0] sym,
    output logic             hit,
    output logic             start_flag,
    output logic             rpt_flag
);
    localparam int DEPTH = 1 << SYM_W;

    logic [DEPTH-1:0] cls_q;

    // Class table: one addressed bit written per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cls_q <= '0;
        else if (cls_we)
            cls_q[cfg_addr] <= cfg_data;
    end

    // Start and report flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            rpt_flag   <= 1'b0;
        end else begin
            if (start_we) start_flag <= cfg_data;
            if (rpt_we)   rpt_flag   <= cfg_data;
        end
    end

    // Lookup of the current symbol.
    assign hit = cls_q[sym];

    // R1: a class write lands at the addressed bit.
    a_r1_class_write: assert property (@(posedge clk) disable iff (!rst_n)
        cls_we |=> (cls_q[$past(cfg_addr)] == $past(cfg_data)));
endmodule

// File: rtl/nfa_route.sv
// Successor routing. It holds the N x N link matrix and forms each
// element's enable as its start flag ORed with every active predecessor
// linked to it. Assumes: the link write strobe is already gated.
module nfa_route #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_we,
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] dst,
    input  logic             data,
    input  logic [N-1:0]     active,
    input  logic [N-1:0]     start,
    output logic [N-1:0]     en
);
    logic [N-1:0] lnk_q [N];

    // Link matrix: row per source element, column per successor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) lnk_q[i] <= '0;
        end else if (link_we) begin
            lnk_q[src][dst] <= data;
        end
    end

    // Enables: start flags plus rows of all active sources.
    always_comb begin
        en = start;
        for (int i = 0; i < N; i++)
            if (active[i]) en = en | lnk_q[i];
    end

    // R3: with nothing active, only start elements can be enabled.
    a_r3_no_active_only_start: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (en == start));
endmodule

// File: rtl/nfa_report.sv
// Report stage. It registers the reporting elements that matched and the
// position of their byte, then gives the lowest reporting index.
// Assumes: fire is high only for a consumed symbol.
module nfa_report #(
    parameter int N     = 16,
    parameter int OFF_W = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [N-1:0]     hits,
    input  logic [OFF_W-1:0] off_in,
    output logic             rpt_valid,
    output logic [N-1:0]     rpt_vec,
    output logic [IDX_W-1:0] rpt_idx,
    output logic [OFF_W-1:0] rpt_offset
);
    // Registered report vector and byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_vec    <= '0;
            rpt_offset <= '0;
        end else begin
            rpt_vec <= fire ? hits : '0;
            if (fire) rpt_offset <= off_in;
        end
    end

    // Lowest set index of the report vector.
    always_comb begin
        rpt_idx = '0;
        for (int k = N - 1; k >= 0; k--)
            if (rpt_vec[k]) rpt_idx = IDX_W'(k);
    end

    assign rpt_valid = |rpt_vec;

    // R6: no report follows a cycle without a consumed symbol.
    a_r6_no_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rpt_valid);

    // R5: the reported index names a reporting element.
    a_r5_idx_in_vec: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> rpt_vec[rpt_idx]);
endmodule

// File: rtl/nfa_matcher.sv
// Top of the parallel NFA symbol matcher. It decodes configuration writes
// (accepted only while the stream is idle), broadcasts the symbol to all
// state elements, keeps the active set and the byte position, and drives
// the report stage. Assumes: SYM_W >= IDX_W so cfg_addr can carry a link
// destination.
module nfa_matcher #(
    parameter int N_STE = 16,
    parameter int SYM_W = 8,
    parameter int OFF_W = 16,
    localparam int IDX_W = $clog2(N_STE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [IDX_W-1:0] cfg_elem,
    input  logic [SYM_W-1:0] cfg_addr,
    input  logic             cfg_data,
    input  logic             restart,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym,
    output logic             rpt_valid,
    output logic [N_STE-1:0] rpt_vec,
    output logic [IDX_W-1:0] rpt_idx,
    output logic [OFF_W-1:0] rpt_offset
);
    import nfa_pkg::*;

    logic             wr_ok;
    cfg_kind_e        kind;
    logic [N_STE-1:0] hit_vec;
    logic [N_STE-1:0] start_vec;
    logic [N_STE-1:0] rflag_vec;
    logic [N_STE-1:0] en_vec;
    logic [N_STE-1:0] active_q;
    logic [N_STE-1:0] next_act;
    logic [OFF_W-1:0] off_q;
    logic             fire;

    assign wr_ok = cfg_we & ~sym_valid;
    assign kind  = cfg_kind_e'(cfg_kind);
    assign fire  = sym_valid & ~restart;

    // State elements, one per index.
    for (genvar k = 0; k < N_STE; k++) begin : g_ste
        logic sel;
        assign sel = wr_ok && (cfg_elem == IDX_W'(k));
        nfa_ste #(.SYM_W(SYM_W)) u_ste (
            .clk        (clk),
            .rst_n      (rst_n),
            .cls_we     (sel && (kind == CFG_CLASS)),
            .start_we   (sel && (kind == CFG_START)),
            .rpt_we     (sel && (kind == CFG_REPORT)),
            .cfg_addr   (cfg_addr),
            .cfg_data   (cfg_data),
            .sym        (sym),
            .hit        (hit_vec[k]),
            .start_flag (start_vec[k]),
            .rpt_flag   (rflag_vec[k])
        );
    end

    nfa_route #(.N(N_STE), .IDX_W(IDX_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_we (wr_ok && (kind == CFG_LINK)),
        .src     (cfg_elem),
        .dst     (cfg_addr[IDX_W-1:0]),
        .data    (cfg_data),
        .active  (active_q),
        .start   (start_vec),
        .en      (en_vec)
    );

    assign next_act = en_vec & hit_vec;

    // Active set and byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            off_q    <= '0;
        end else if (restart) begin
            active_q <= '0;
            off_q    <= '0;
        end else if (sym_valid) begin
            active_q <= next_act;
            off_q    <= off_q + 1'b1;
        end
    end

    nfa_report #(.N(N_STE), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .hits       (next_act & rflag_vec),
        .off_in     (off_q),
        .rpt_valid  (rpt_valid),
        .rpt_vec    (rpt_vec),
        .rpt_idx    (rpt_idx),
        .rpt_offset (rpt_offset)
    );

    // R6: idle cycles leave the active set alone.
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !restart) |=> $stable(active_q));

    // R8: restart empties the active set.
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (active_q == '0));

    // R4: an element only turns active if it was enabled.
    a_r4_active_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((active_q & ~$past(en_vec)) == '0));
endmodule

// File: tb/sim_nfa_matcher.sv
module sim_nfa_matcher;
    localparam int N     = 16;
    localparam int SYM_W = 8;
    localparam int OFF_W = 16;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_kind = '0;
    logic [IDX_W-1:0] cfg_elem = '0;
    logic [SYM_W-1:0] cfg_addr = '0;
    logic             cfg_data = 1'b0;
    logic             restart = 1'b0;
    logic             sym_valid = 1'b0;
    logic [SYM_W-1:0] sym = '0;
    logic             rpt_valid;
    logic [N-1:0]     rpt_vec;
    logic [IDX_W-1:0] rpt_idx;
    logic [OFF_W-1:0] rpt_offset;

    int checks = 0;
    int failures = 0;
    string cur_req = "R9";

    always #4 clk = ~clk;

    nfa_matcher #(.N_STE(N), .SYM_W(SYM_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_elem(cfg_elem), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .restart(restart), .sym_valid(sym_valid), .sym(sym),
        .rpt_valid(rpt_valid), .rpt_vec(rpt_vec), .rpt_idx(rpt_idx),
        .rpt_offset(rpt_offset)
    );

    // Behavioural reference model.
    bit         mtbl  [N][256];
    bit         mlink [N][N];
    bit         mst   [N];
    bit         mrf   [N];
    bit [N-1:0] mact;
    bit [N-1:0] exp_vec;
    int         moff;
    int         exp_off;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                for (int s = 0; s < 256; s++) mtbl[i][s] = 1'b0;
                for (int j = 0; j < N; j++) mlink[i][j] = 1'b0;
                mst[i] = 1'b0;
                mrf[i] = 1'b0;
            end
            mact = '0; exp_vec = '0; moff = 0; exp_off = 0;
        end else begin
            if (restart) begin
                mact = '0; moff = 0; exp_vec = '0;
            end else if (sym_valid) begin
                bit [N-1:0] nact;
                bit [N-1:0] nrep;
                for (int j = 0; j < N; j++) begin
                    bit e;
                    e = mst[j];
                    for (int i = 0; i < N; i++)
                        if (mact[i] && mlink[i][j]) e = 1'b1;
                    nact[j] = e && mtbl[j][sym];
                    nrep[j] = nact[j] && mrf[j];
                end
                mact = nact; exp_vec = nrep; exp_off = moff; moff++;
            end else begin
                exp_vec = '0;
            end
            if (cfg_we && !sym_valid) begin
                case (cfg_kind)
                    2'd0: mtbl[cfg_elem][cfg_addr] = cfg_data;
                    2'd1: mlink[cfg_elem][cfg_addr[IDX_W-1:0]] = cfg_data;
                    2'd2: mst[cfg_elem] = cfg_data;
                    default: mrf[cfg_elem] = cfg_data;
                endcase
            end
        end
    end

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        int lo;
        chk("rpt_valid", rpt_valid, exp_vec != '0);
        chk("rpt_vec", rpt_vec, exp_vec);
        if (exp_vec != '0) begin
            lo = 0;
            for (int k = N - 1; k >= 0; k--) if (exp_vec[k]) lo = k;
            chk("rpt_idx", rpt_idx, lo);
            chk("rpt_offset", rpt_offset, exp_off & 16'hFFFF);
        end
    end

    task automatic cfg(int kind, int elem, int addr, bit data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_elem = IDX_W'(elem);
        cfg_addr = SYM_W'(addr); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(byte b);
        @(negedge clk);
        sym_valid = 1'b1; sym = b;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic send_str(string s);
        @(negedge clk);
        for (int k = 0; k < s.len(); k++) begin
            sym_valid = 1'b1; sym = s[k];
            @(negedge clk);
        end
        sym_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: reset state, then bytes with nothing programmed.
        cur_req = "R9";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        send_str("cat, .xyz");
        idle(2);

        // R1/R3/R5: three-element chain for "cat".
        cur_req = "R1";
        cfg(2, 0, 0, 1); cfg(0, 0, "c", 1);
        cfg(1, 0, 1, 1); cfg(0, 1, "a", 1);
        cfg(1, 1, 2, 1); cfg(0, 2, "t", 1); cfg(3, 2, 0, 1);
        cur_req = "R3";
        send_str("xcatcatt");
        idle(2);

        // R2: pattern starting at any position, back to back.
        cur_req = "R2";
        send_str("ccatacatcat");
        idle(2);

        // R1: one element accepting a class of terminators.
        cur_req = "R1";
        cfg(2, 3, 0, 1); cfg(3, 3, 0, 1);
        cfg(0, 3, " ", 1); cfg(0, 3, ",", 1); cfg(0, 3, ".", 1); cfg(0, 3, 8'h0d, 1);
        send_str("a b,c.d\re!");
        idle(2);

        // R3: one element fanning out to three parallel successors.
        cur_req = "R3";
        cfg(2, 4, 0, 1); cfg(0, 4, "k", 1);
        cfg(1, 4, 5, 1); cfg(1, 4, 6, 1); cfg(1, 4, 7, 1);
        cfg(0, 5, "a", 1); cfg(0, 6, "a", 1); cfg(0, 7, "o", 1);
        cfg(3, 5, 0, 1); cfg(3, 6, 0, 1); cfg(3, 7, 0, 1);
        send_str("kakokk");
        idle(2);

        // R4: failing comparisons part way through.
        cur_req = "R4";
        send_str("cxtcaxcct");
        idle(2);

        // R6: idle gaps inside a pattern.
        cur_req = "R6";
        send("c"); idle(3); send("a"); idle(5); send("t");
        idle(3);

        // R7: writes during a valid byte are ignored.
        cur_req = "R7";
        cfg(0, 8, "z", 1); cfg(3, 8, 0, 1);
        @(negedge clk);
        sym_valid = 1'b1; sym = "q";
        cfg_we = 1'b1; cfg_kind = 2'd2; cfg_elem = IDX_W'(8); cfg_data = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0; cfg_we = 1'b0;
        send_str("zz");
        cfg(2, 8, 0, 1);
        send_str("zqz");
        idle(2);

        // R8: restart between bytes, and restart with a byte in the same cycle.
        cur_req = "R8";
        send_str("ca");
        do_restart();
        send_str("t");
        send_str("c");
        @(negedge clk);
        restart = 1'b1; sym_valid = 1'b1; sym = "a";
        @(negedge clk);
        restart = 1'b0; sym_valid = 1'b0;
        send_str("tcat");
        idle(2);

        // R5: report positions after a restart.
        cur_req = "R5";
        do_restart();
        send_str("zcatk");
        idle(3);

        finish_run();
    end
endmodule